// File: doc/BRIEF.md
# Variable-Page-Size Translation Entry Matcher

This block decides, in a single combinational pass, whether one stored address-translation entry applies to a given virtual address in a given address-space context. When it does, the block also builds the physical address. Each entry carries its own page size, so the dividing line between translated and untranslated address bits moves from entry to entry.

A translation lookup places one copy of this matcher beside each entry slot. It feeds the slot's tag word, its data word, the virtual address being looked up and the current context into the matcher. It then combines the per-slot hit flags and physical addresses outside this block. The decoded page mask is also brought out, so that neighbouring logic can reuse the boundary without decoding it again.

Top module: `tlb_entry_match`

## Requirements
- R1: The page-size code is data-word bits 62:61. Codes 0, 1, 2 and 3 select 8 KB, 64 KB, 512 KB and 4 MB pages. `page_mask` is all ones above the page offset, with the low 13, 16, 19 or 22 bits cleared respectively.
- R2: When data-word bit 63 (valid) is 0, `hit` is 0 whatever the other inputs are.
- R3: The context check compares only `entry_tag[12:0]` against `cur_ctx`. A difference in any one of those 13 bits forces `hit` to 0.
- R4: The address check passes when `vaddr` and `entry_tag` agree on every bit set in `page_mask`. Differences in bits below the page boundary never affect `hit`.
- R5: `hit` is 1 exactly when the valid bit is set, the context check passes and the address check passes.
- R6: On a hit, `paddr` bits 40:13 take data-word bits where `page_mask` is 1 and `vaddr` bits where it is 0. `paddr[12:0]` is always 0.
- R7: When `hit` is 0, `paddr` is all zeros.
- R8: Data-word bits 60:41 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| entry_tag | input | 64 | Entry tag: virtual page bits above the offset, context in bits 12:0 |
| entry_data | input | 64 | Entry data: valid (63), size code (62:61), physical page bits |
| vaddr | input | 64 | Virtual address being translated |
| cur_ctx | input | 13 | Current address-space context |
| hit | output | 1 | Entry applies to this address and context |
| paddr | output | 41 | Translated physical address, zero on a miss |
| page_mask | output | 64 | Page-number mask decoded from the size code |

## Verification
For each page size, the address is walked through every single-bit difference from the tag. A difference one bit below the page boundary must still hit, while a difference at the boundary bit must miss. This separates a correct boundary from one shifted by a single position. Single-bit context differences and a cleared valid bit confirm that each term of the hit condition can veto a match on its own. Toggling the unused data bits shows that they are ignored. Random tag, data, address and context patterns, with many forced matches, check the merge of the physical address on both sides of the boundary and the zero output on a miss.

// File: rtl/tlb_match_pkg.sv
package tlb_match_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned CTX_W      = 13;
  localparam int unsigned VALID_POS  = 63;
  localparam int unsigned SIZE_HI    = 62;
  localparam int unsigned SIZE_LO    = 61;
  localparam int unsigned SIZE_W     = SIZE_HI - SIZE_LO + 1;
  localparam int unsigned PA_HI      = 40;
  localparam int unsigned OFF_MIN    = 13;
  localparam int unsigned OFF_STEP   = 3;

  typedef enum logic [SIZE_W-1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } page_size_e;
endpackage

// File: rtl/tlb_page_mask_dec.sv
module tlb_page_mask_dec #(
  parameter int unsigned ADDR_W   = tlb_match_pkg::ADDR_W,
  parameter int unsigned SIZE_W   = tlb_match_pkg::SIZE_W,
  parameter int unsigned OFF_MIN  = tlb_match_pkg::OFF_MIN,
  parameter int unsigned OFF_STEP = tlb_match_pkg::OFF_STEP
) (
  input  logic [SIZE_W-1:0] size_code,
  output logic [ADDR_W-1:0] mask
);
  localparam int unsigned NUM_SIZES = 1 << SIZE_W;

  logic [ADDR_W-1:0] cand [NUM_SIZES];

  // One candidate mask per page size, offset growing by OFF_STEP each step
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_cand
    localparam int unsigned OFF = OFF_MIN + g * OFF_STEP;
    assign cand[g] = {ADDR_W{1'b1}} << OFF;
  end

  always_comb begin
    mask = cand[size_code];
  end
endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int unsigned ADDR_W = tlb_match_pkg::ADDR_W,
  parameter int unsigned CTX_W  = tlb_match_pkg::CTX_W
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] tag,
  input  logic [ADDR_W-1:0] va,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [ADDR_W-1:0] mask,
  output logic              match
);
  logic ctx_eq;
  logic va_eq;

  always_comb begin
    ctx_eq = (tag[CTX_W-1:0] == ctx);
    va_eq  = ((va & mask) == (tag & mask));
    match  = valid & ctx_eq & va_eq;
  end
endmodule

// File: rtl/tlb_pa_form.sv
module tlb_pa_form #(
  parameter int unsigned PA_W    = tlb_match_pkg::PA_HI + 1,
  parameter int unsigned OFF_MIN = tlb_match_pkg::OFF_MIN
) (
  input  logic            hit,
  input  logic [PA_W-1:0] data,
  input  logic [PA_W-1:0] va,
  input  logic [PA_W-1:0] mask,
  output logic [PA_W-1:0] pa
);
  localparam logic [PA_W-1:0] KEEP = {PA_W{1'b1}} << OFF_MIN;

  logic [PA_W-1:0] merged;

  always_comb begin
    merged = ((data & mask) | (va & ~mask)) & KEEP;
    pa     = hit ? merged : '0;
  end
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_match_pkg::*;
(
  input  logic [ADDR_W-1:0] entry_tag,
  input  logic [ADDR_W-1:0] entry_data,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [CTX_W-1:0]  cur_ctx,
  output logic              hit,
  output logic [PA_HI:0]    paddr,
  output logic [ADDR_W-1:0] page_mask
);
  localparam int unsigned PA_W = PA_HI + 1;

  logic [SIZE_W-1:0] size_code;
  logic              entry_valid;
  logic              unused_data_bits;

  assign size_code        = entry_data[SIZE_HI:SIZE_LO];
  assign entry_valid      = entry_data[VALID_POS];
  assign unused_data_bits = ^entry_data[SIZE_LO-1:PA_W];

  tlb_page_mask_dec #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_MIN(OFF_MIN), .OFF_STEP(OFF_STEP)
  ) u_mask (
    .size_code (size_code),
    .mask      (page_mask)
  );

  tlb_tag_cmp #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W)
  ) u_cmp (
    .valid (entry_valid),
    .tag   (entry_tag),
    .va    (vaddr),
    .ctx   (cur_ctx),
    .mask  (page_mask),
    .match (hit)
  );

  tlb_pa_form #(
    .PA_W(PA_W), .OFF_MIN(OFF_MIN)
  ) u_pa (
    .hit  (hit),
    .data (entry_data[PA_W-1:0]),
    .va   (vaddr[PA_W-1:0]),
    .mask (page_mask[PA_W-1:0]),
    .pa   (paddr)
  );
endmodule

// File: rtl/tlb_entry_match_chk.sv
module tlb_entry_match_chk
  import tlb_match_pkg::*;
(
  input logic [ADDR_W-1:0] entry_tag,
  input logic [ADDR_W-1:0] entry_data,
  input logic [ADDR_W-1:0] vaddr,
  input logic [CTX_W-1:0]  cur_ctx,
  input logic              hit,
  input logic [PA_HI:0]    paddr,
  input logic [ADDR_W-1:0] page_mask
);
  logic known;
  logic [ADDR_W-1:0] low_bit;

  always_comb begin
    known   = !$isunknown({entry_tag, entry_data, vaddr, cur_ctx});
    low_bit = page_mask & (~page_mask + 1'b1);
    if (known) begin
      // R1
      mask_shape_chk: assert (page_mask[OFF_MIN-1:0] == '0 &&
                              (page_mask + low_bit) == '0 &&
                              $countones(page_mask) >= ADDR_W - OFF_MIN - 3 * OFF_STEP);
      // R2
      invalid_no_hit_chk: assert (entry_data[VALID_POS] || !hit);
      // R3
      ctx_veto_chk: assert (entry_tag[CTX_W-1:0] == cur_ctx || !hit);
      // R4
      va_agree_chk: assert (!hit || ((vaddr ^ entry_tag) & page_mask) == '0);
      // R6
      pa_offset_zero_chk: assert (paddr[OFF_MIN-1:0] == '0);
      // R7
      pa_zero_on_miss_chk: assert (hit || paddr == '0);
    end
  end
endmodule

bind tlb_entry_match tlb_entry_match_chk u_chk (
  .entry_tag  (entry_tag),
  .entry_data (entry_data),
  .vaddr      (vaddr),
  .cur_ctx    (cur_ctx),
  .hit        (hit),
  .paddr      (paddr),
  .page_mask  (page_mask)
);

// File: tb/tlb_entry_match_bench.sv
module tlb_entry_match_bench;
  localparam time CLK_HALF = 10ns;

  logic        clk;
  logic [63:0] entry_tag, entry_data, vaddr;
  logic [12:0] cur_ctx;
  logic        hit;
  logic [40:0] paddr;
  logic [63:0] page_mask;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  tlb_entry_match u_tlb_entry_match (
    .entry_tag (entry_tag), .entry_data (entry_data), .vaddr (vaddr),
    .cur_ctx (cur_ctx), .hit (hit), .paddr (paddr), .page_mask (page_mask)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic apply(input logic [63:0] t, input logic [63:0] d,
                       input logic [63:0] v, input logic [12:0] c, input string req);
    int          sh;
    logic [63:0] m, full;
    logic        eh;
    logic [40:0] ep;
    @(posedge clk);
    entry_tag = t; entry_data = d; vaddr = v; cur_ctx = c;
    sh   = 13 + 3 * int'(d[62:61]);
    m    = ~64'd0 << sh;
    eh   = d[63] && (t[12:0] == c) && ((v & m) == (t & m));
    full = ((d & m) | (v & ~m)) & 64'h0000_01FF_FFFF_E000;
    ep   = eh ? full[40:0] : 41'd0;
    @(negedge clk);
    n_vec++;
    if (hit !== eh || paddr !== ep || page_mask !== m) begin
      n_fail++;
      $display("FAIL %s: hit=%b pa=%h mask=%h expected hit=%b pa=%h mask=%h",
               req, hit, paddr, page_mask, eh, ep, m);
    end
  endtask

  initial begin
    logic [63:0] t, d, v;
    logic [12:0] c;
    entry_tag = '0; entry_data = '0; vaddr = '0; cur_ctx = '0;
    // R2: all-zero inputs, invalid entry, no hit
    apply(64'd0, 64'd0, 64'd0, 13'd0, "R2 idle");
    for (int code = 0; code < 4; code++) begin
      t = {$urandom, $urandom};
      c = t[12:0];
      d = {1'b1, 2'(code), 61'h0ABC_DEF0_1234_5678};
      v = {t[63:13], 13'(($urandom))};
      // R1 R4 R6: single-bit walk, hit below boundary, miss at and above it
      for (int b = 0; b < 64; b++)
        apply(t, d, v ^ (64'd1 << b), c, "R1/R4/R6 bit walk");
      // R2: valid cleared
      apply(t, {1'b0, d[62:0]}, v, c, "R2 invalid");
      // R3: each context bit
      for (int b = 0; b < 13; b++)
        apply(t, d, v, c ^ 13'(1 << b), "R3 ctx bit");
      // R8: unused data bits toggled
      for (int b = 41; b < 61; b++)
        apply(t, d ^ (64'd1 << b), v, c, "R8 unused bit");
    end
    // R5 R6 R7: random patterns, half forced to match
    for (int i = 0; i < 3000; i++) begin
      t = {$urandom, $urandom};
      d = {$urandom, $urandom};
      v = {$urandom, $urandom};
      c = 13'($urandom);
      if (i % 2 == 0) begin
        c = t[12:0];
        v = {t[63:22], v[21:0]};
        d[63] = 1'b1;
      end
      apply(t, d, v, c, "R5/R6/R7 random");
    end
    done = 1;
  end

  initial begin
    for (int k = 0; k < 200000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule